// File: doc/BRIEF.md
# Single-Register Raw NAND Flash Bridge

This block lets a processor run an 8-bit raw NAND flash through one 32-bit memory-mapped register. A register write holds a small operation code, a chip-enable request and one byte. The bridge turns that write into one of four actions: a command latch cycle, an address latch cycle, a data write cycle, or the arming of read mode. Each flash cycle comes with properly timed latch, chip-enable and write strobes.

A register read always reports whether the flash is busy. Once read mode is armed, each register read also pulses the read strobe and returns the byte the flash put on the bus. Software reads a page by arming read mode once and then reading the register once per byte.

The bus side uses a request/acknowledge handshake. The acknowledge is held back until the flash strobe sequence of the access has finished, so two accesses can never overlap on the flash pins. Strobe low and high times are parameters given in clock cycles.

Top module: `nand_reg_bridge`

## Requirements
- R1: Write-word bits 30:28 select the action: 0 gives a command latch cycle with CLE high, 1 gives an address latch cycle with ALE high, 3 gives a data write cycle with CLE and ALE both low, and 2 arms read mode.
- R2: Write-word bit 31 is the chip-enable request. When it is 1, nand_ce_n is low around the flash cycle. When it is 0, nand_ce_n stays high. The flag given with the read-arm write applies to every read strobe that follows.
- R3: The byte in write-word bits 23:16 is the value on nand_dq at the rising edge of nand_we_n.
- R4: Read-word bit 15 is 1 while nand_rb_n is low (busy) and 0 while it is high (ready), seen through a SYNC_STAGES-flop synchronizer.
- R5: Each command, address or data write access produces exactly one nand_we_n pulse. The read-arm write produces no strobe.
- R6: While read mode is armed, each register read produces exactly one nand_re_n pulse and returns the sampled flash byte in read-word bits 23:16. Successive reads return successive flash bytes.
- R7: nand_we_n stays low for T_WL cycles and nand_re_n for T_RL cycles. After nand_we_n rises, the data, latch and chip-enable levels are held for T_WH more cycles. Data and latches are stable throughout the low phase.
- R8: bus_ack is a one-cycle pulse. It comes only after the access's strobe sequence has ended, when nand_we_n and nand_re_n are high and nand_ce_n has been released.
- R9: A write with any operation code other than 2 (including the unused codes 4 to 7, which drive no strobe) ends read mode. Reads after that produce no nand_re_n pulse and return zero in bits 23:16.
- R10: During and after reset, nand_ce_n, nand_we_n and nand_re_n are high and CLE and ALE are low.
- R11: CLE and ALE are never high together, and nand_we_n and nand_re_n are never low together.
- R12: All read-word bits other than 23:16 and 15 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_we | input | 1 | 1 = register write, 0 = register read |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access completion |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq | inout | 8 | Flash data bus |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The assertions assume the bus master keeps bus_req, bus_we and bus_wdata steady until it sees bus_ack and then drops bus_req. They also assume the flash drives nand_dq only while nand_re_n is low. The bench tasks raise a request at a falling clock edge, wait for the acknowledge and release the request at once. The flash model in the bench drives the data bus only while the read strobe is low. nand_rb_n may change at any time, because it is synchronized inside the block.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int EN_POS   = 31;
  localparam int OP_LSB   = 28;
  localparam int OP_W     = 3;
  localparam int VAL_LSB  = 16;
  localparam int BUSY_POS = 15;

  localparam logic [OP_W-1:0] OP_CMD   = 3'd0;
  localparam logic [OP_W-1:0] OP_ADDR  = 3'd1;
  localparam logic [OP_W-1:0] OP_RDARM = 3'd2;
  localparam logic [OP_W-1:0] OP_WDATA = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WLOW,
    ST_WHIGH,
    ST_RSETUP,
    ST_RLOW,
    ST_RHIGH,
    ST_DONE
  } xfer_state_t;

  typedef struct packed {
    logic              ce_req;
    logic [OP_W-1:0]   op;
    logic [BYTE_W-1:0] val;
  } wr_fields_t;

  function automatic wr_fields_t split_word(input logic [WORD_W-1:0] w);
    wr_fields_t f;
    f.ce_req = w[EN_POS];
    f.op     = w[OP_LSB +: OP_W];
    f.val    = w[VAL_LSB +: BYTE_W];
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic [BYTE_W-1:0] b,
                                                    input logic busy);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VAL_LSB +: BYTE_W] = b;
    w[BUSY_POS] = busy;
    return w;
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_n_async,
  output logic busy
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= rb_n_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], rb_n_async};
      end
    end
  endgenerate

  assign busy = ~chain[STAGES-1];

endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/nand_bridge_fsm.sv
module nand_bridge_fsm
  import nand_bridge_pkg::*;
#(
  parameter int T_WL = 3,
  parameter int T_WH = 2,
  parameter int T_RL = 3,
  parameter int T_RH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  wr_fields_t        wf,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ack,
  input  logic              busy,
  input  logic [BYTE_W-1:0] dq_in,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic              dq_oe,
  output logic [BYTE_W-1:0] dq_out
);

  localparam int TMAX = (T_WL > T_WH ? (T_WL > T_RL ? (T_WL > T_RH ? T_WL : T_RH)
                                                    : (T_RL > T_RH ? T_RL : T_RH))
                                     : (T_WH > T_RL ? (T_WH > T_RH ? T_WH : T_RH)
                                                    : (T_RL > T_RH ? T_RL : T_RH)));
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LD_WL = CW'(T_WL - 1);
  localparam logic [CW-1:0] LD_WH = CW'(T_WH - 1);
  localparam logic [CW-1:0] LD_RL = CW'(T_RL - 1);
  localparam logic [CW-1:0] LD_RH = CW'(T_RH - 1);

  xfer_state_t       state;
  logic              rd_mode;
  logic              rd_ce;
  logic [BYTE_W-1:0] rd_byte;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;
  logic              tmr_done;

  nand_strobe_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_SETUP:  begin tmr_load = 1'b1;     tmr_val = LD_WL; end
      ST_WLOW:   begin tmr_load = tmr_done; tmr_val = LD_WH; end
      ST_RSETUP: begin tmr_load = 1'b1;     tmr_val = LD_RL; end
      ST_RLOW:   begin tmr_load = tmr_done; tmr_val = LD_RH; end
      default:   begin tmr_load = 1'b0;     tmr_val = '0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ce_n      <= 1'b1;
      cle       <= 1'b0;
      ale       <= 1'b0;
      we_n      <= 1'b1;
      re_n      <= 1'b1;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      rd_mode   <= 1'b0;
      rd_ce     <= 1'b0;
      rd_byte   <= '0;
    end else begin
      bus_ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (bus_req) begin
            if (bus_we) begin
              if (wf.op == OP_CMD || wf.op == OP_ADDR || wf.op == OP_WDATA) begin
                cle     <= (wf.op == OP_CMD);
                ale     <= (wf.op == OP_ADDR);
                ce_n    <= ~wf.ce_req;
                dq_out  <= wf.val;
                dq_oe   <= 1'b1;
                rd_mode <= 1'b0;
                state   <= ST_SETUP;
              end else if (wf.op == OP_RDARM) begin
                rd_mode   <= 1'b1;
                rd_ce     <= wf.ce_req;
                bus_ack   <= 1'b1;
                bus_rdata <= '0;
                state     <= ST_DONE;
              end else begin
                rd_mode   <= 1'b0;
                bus_ack   <= 1'b1;
                bus_rdata <= '0;
                state     <= ST_DONE;
              end
            end else if (rd_mode) begin
              ce_n  <= ~rd_ce;
              state <= ST_RSETUP;
            end else begin
              bus_ack   <= 1'b1;
              bus_rdata <= pack_status('0, busy);
              state     <= ST_DONE;
            end
          end
        end
        ST_SETUP: begin
          we_n  <= 1'b0;
          state <= ST_WLOW;
        end
        ST_WLOW: begin
          if (tmr_done) begin
            we_n  <= 1'b1;
            state <= ST_WHIGH;
          end
        end
        ST_WHIGH: begin
          if (tmr_done) begin
            cle       <= 1'b0;
            ale       <= 1'b0;
            ce_n      <= 1'b1;
            dq_oe     <= 1'b0;
            bus_ack   <= 1'b1;
            bus_rdata <= '0;
            state     <= ST_DONE;
          end
        end
        ST_RSETUP: begin
          re_n  <= 1'b0;
          state <= ST_RLOW;
        end
        ST_RLOW: begin
          if (tmr_done) begin
            re_n    <= 1'b1;
            rd_byte <= dq_in;
            state   <= ST_RHIGH;
          end
        end
        ST_RHIGH: begin
          if (tmr_done) begin
            ce_n      <= 1'b1;
            bus_ack   <= 1'b1;
            bus_rdata <= pack_status(rd_byte, busy);
            state     <= ST_DONE;
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
  import nand_bridge_pkg::*;
#(
  parameter int T_WL        = 3,
  parameter int T_WH        = 2,
  parameter int T_RL        = 3,
  parameter int T_RH        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ack,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  inout  wire  [7:0]  nand_dq,
  input  logic        nand_rb_n
);

  wr_fields_t        wf;
  logic              busy;
  logic              dq_oe;
  logic [BYTE_W-1:0] dq_out;
  logic              unused_wbits;

  assign wf = split_word(bus_wdata);
  assign unused_wbits = ^{bus_wdata[27:24], bus_wdata[15:0]};

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .rb_n_async (nand_rb_n),
    .busy       (busy)
  );

  nand_bridge_fsm #(
    .T_WL (T_WL),
    .T_WH (T_WH),
    .T_RL (T_RL),
    .T_RH (T_RH)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .wf        (wf),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .busy      (busy),
    .dq_in     (nand_dq),
    .ce_n      (nand_ce_n),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out)
  );

  assign nand_dq = dq_oe ? dq_out : 8'bz;

endmodule

// File: rtl/nand_bridge_checker.sv
module nand_bridge_checker #(
  parameter int T_WL = 3,
  parameter int T_RL = 3
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_ack,
  input logic [31:0] bus_rdata,
  input logic        nand_ce_n,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic        nand_we_n,
  input logic        nand_re_n,
  input logic [7:0]  nand_dq
);

  logic [15:0] we_lo_cnt;
  logic [15:0] re_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_cnt <= '0;
      re_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= nand_we_n ? 16'd0 : we_lo_cnt + 16'd1;
      re_lo_cnt <= nand_re_n ? 16'd0 : re_lo_cnt + 16'd1;
    end
  end

  // R7: write strobe low width
  p_we_width_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |-> we_lo_cnt == 16'(T_WL));

  // R7: read strobe low width
  p_re_width_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_re_n) |-> re_lo_cnt == 16'(T_RL));

  // R7 / R3: data and latch levels stable while the write strobe is low
  p_dq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_dq) && $stable(nand_cle)
                                           && $stable(nand_ale) && $stable(nand_ce_n)));

  // R3: data unchanged across the write strobe rising edge
  p_dq_at_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |-> $stable(nand_dq));

  // R11: latch enables exclusive
  p_latch_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  // R11: strobes exclusive
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  // R8: acknowledge is a single pulse after the strobes are released
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  p_ack_idle_r8: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> (nand_we_n && nand_re_n && nand_ce_n));

  // R12: unused read bits are zero
  p_unused_zero_r12: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> ((bus_rdata & 32'hFF00_7FFF) == 32'h0));

  // R10: reset drives the idle pin levels
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale));

endmodule

bind nand_reg_bridge nand_bridge_checker #(.T_WL(T_WL), .T_RL(T_RL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_ack   (bus_ack),
  .bus_rdata (bus_rdata),
  .nand_ce_n (nand_ce_n),
  .nand_cle  (nand_cle),
  .nand_ale  (nand_ale),
  .nand_we_n (nand_we_n),
  .nand_re_n (nand_re_n),
  .nand_dq   (nand_dq)
);

// File: tb/nand_reg_bridge_test.sv
module nand_reg_bridge_test;

  localparam int CLK_PERIOD = 10;
  localparam int P_WL = 3;
  localparam int P_WH = 2;
  localparam int P_RL = 4;
  localparam int P_RH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  wire  [7:0]  nand_dq;
  logic        nand_rb_n = 1'b1;

  int checks = 0;
  int errors = 0;

  // flash model state
  int         fptr = 0;
  int         we_pulses = 0, re_pulses = 0;
  int         we_lo = 0, re_lo = 0, we_lo_last = 0, re_lo_last = 0;
  int         hold_cnt = 0;
  bit         hold_act = 0;
  logic       we_prev = 1'b1, re_prev = 1'b1;
  logic       s_cle, s_ale, s_ce_n, r_ce_n;
  logic [7:0] s_dq;
  logic       c_cle = 0, c_ale = 0, c_ce_n = 1, c_re_ce_n = 1;
  logic [7:0] c_dq = 0;

  function automatic logic [7:0] fbyte(input int idx);
    return 8'((idx * 37) + 8'h5A);
  endfunction

  function automatic logic [31:0] mkword(input bit en, input logic [2:0] op,
                                         input logic [7:0] v);
    return {en, op, 4'h0, v, 16'h0};
  endfunction

  assign nand_dq = (!nand_re_n) ? fbyte(fptr) : 8'bz;

  nand_reg_bridge #(
    .T_WL(P_WL), .T_WH(P_WH), .T_RL(P_RL), .T_RH(P_RH), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq(nand_dq),
    .nand_rb_n(nand_rb_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // pin monitor sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (!nand_we_n) begin
        we_lo++;
        s_cle = nand_cle; s_ale = nand_ale; s_ce_n = nand_ce_n; s_dq = nand_dq;
      end
      if (nand_we_n && !we_prev) begin
        we_pulses++;
        we_lo_last = we_lo; we_lo = 0;
        c_cle = s_cle; c_ale = s_ale; c_ce_n = s_ce_n; c_dq = s_dq;
        hold_act = 1; hold_cnt = nand_ce_n ? 0 : 1;
        if (nand_ce_n) hold_act = 0;
      end else if (hold_act) begin
        if (nand_ce_n) hold_act = 0;
        else hold_cnt++;
      end
      if (!nand_re_n) begin
        re_lo++;
        r_ce_n = nand_ce_n;
      end
      if (nand_re_n && !re_prev) begin
        re_pulses++;
        re_lo_last = re_lo; re_lo = 0;
        c_re_ce_n = r_ce_n;
        fptr++;
      end
      we_prev = nand_we_n;
      re_prev = nand_re_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] w);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_wdata = w;
    do @(negedge clk); while (!bus_ack);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(output logic [31:0] r);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0;
    do @(negedge clk); while (!bus_ack);
    r = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic do_flash_write(input bit en, input logic [2:0] op, input logic [7:0] v);
    int p0;
    p0 = we_pulses;
    bus_write(mkword(en, op, v));
    chk(we_pulses == p0 + 1, "R5 one WE pulse", we_pulses - p0, 1);
    chk(c_cle == (op == 3'd0) && c_ale == (op == 3'd1), "R1 latch select",
        {c_cle, c_ale}, {(op == 3'd0), (op == 3'd1)});
    chk(c_ce_n == !en, "R2 chip enable", c_ce_n, !en);
    chk(c_dq == v, "R3 data at WE rise", c_dq, v);
    chk(we_lo_last == P_WL, "R7 WE low time", we_lo_last, P_WL);
    if (en) chk(hold_cnt == P_WH, "R7 WE high hold", hold_cnt, P_WH);
    chk(nand_we_n && nand_re_n && nand_ce_n && !nand_cle && !nand_ale,
        "R8 pins idle at ack", {nand_we_n, nand_re_n, nand_ce_n, nand_cle, nand_ale}, 5'b11100);
  endtask

  int exp_idx = 0;

  task automatic read_burst(input bit en, input int n);
    logic [31:0] r;
    int p0, w0;
    p0 = re_pulses; w0 = we_pulses;
    bus_write(mkword(en, 3'd2, 8'hA5));
    chk(re_pulses == p0 && we_pulses == w0, "R5 arm has no strobe",
        re_pulses - p0 + we_pulses - w0, 0);
    for (int i = 0; i < n; i++) begin
      p0 = re_pulses;
      bus_read(r);
      chk(re_pulses == p0 + 1, "R6 one RE pulse", re_pulses - p0, 1);
      chk(r[23:16] == fbyte(exp_idx), "R6 read byte", r[23:16], fbyte(exp_idx));
      chk((r & 32'hFF00_7FFF) == 0, "R12 unused bits", r, r & 32'h00FF_8000);
      chk(re_lo_last == P_RL, "R7 RE low time", re_lo_last, P_RL);
      chk(c_re_ce_n == !en, "R2 CE during read", c_re_ce_n, !en);
      exp_idx++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int p0;
    void'($urandom(32'd7331));
    repeat (4) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
        "R10 pins during reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
        "R10 pins after reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
    bus_read(r);
    chk(r == 32'h0, "R10 status after reset", r, 0);

    // directed: each opcode with enable
    do_flash_write(1'b1, 3'd0, 8'h90);
    do_flash_write(1'b1, 3'd1, 8'h00);
    do_flash_write(1'b1, 3'd3, 8'hFF);
    do_flash_write(1'b0, 3'd3, 8'h3C);

    // busy flag through the synchronizer
    nand_rb_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(r);
    chk(r == 32'h0000_8000, "R4 busy reported", r, 32'h0000_8000);
    nand_rb_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(r);
    chk(r == 32'h0, "R4 ready reported", r, 0);

    // constrained random writes
    for (int i = 0; i < 40; i++) begin
      logic [1:0] sel;
      logic [2:0] op;
      sel = 2'($urandom_range(0, 2));
      op = (sel == 2'd0) ? 3'd0 : (sel == 2'd1) ? 3'd1 : 3'd3;
      do_flash_write(1'($urandom_range(0, 1)), op, 8'($urandom));
    end

    // read bursts
    read_burst(1'b1, 5);
    read_burst(1'b0, 2);
    for (int i = 0; i < 4; i++) read_burst(1'($urandom_range(0, 1)), $urandom_range(1, 6));

    // busy bit alongside read data
    nand_rb_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(r);
    chk(r[15] == 1'b1, "R4 busy with read data", r[15], 1);
    chk(r[23:16] == fbyte(exp_idx), "R6 byte while busy", r[23:16], fbyte(exp_idx));
    exp_idx++;
    nand_rb_n = 1'b1;

    // read mode ended by a data write
    do_flash_write(1'b1, 3'd3, 8'h11);
    p0 = re_pulses;
    bus_read(r);
    chk(re_pulses == p0 && r[23:16] == 8'h00, "R9 read mode ended by write",
        {re_pulses - p0, r[23:16]}, 0);

    // read mode ended by an unused opcode, which drives no strobe
    read_burst(1'b1, 1);
    p0 = we_pulses;
    bus_write(mkword(1'b1, 3'd5, 8'h77));
    chk(we_pulses == p0, "R9 unused opcode no WE", we_pulses - p0, 0);
    p0 = re_pulses;
    bus_read(r);
    chk(re_pulses == p0 && r == 32'h0, "R9 read mode ended by unused opcode",
        r, 0);

    // back-to-back writes keep separate pulses
    p0 = we_pulses;
    for (int i = 0; i < 3; i++) bus_write(mkword(1'b1, 3'd3, 8'(i)));
    chk(we_pulses == p0 + 3, "R8 back-to-back pulses", we_pulses - p0, 3);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule